// File: doc/BRIEF.md
# Tick Counter with Three Compare Matches

This block keeps a 32-bit count that moves forward by one on every pulse of a slow tick enable, nominally 32768 Hz, supplied as a single-cycle strobe in the system clock domain. Software reaches it through a 32-bit register window. In that window it can program a shared control word, preset the count, read the count, and program a number of compare values (three by default). When the count steps onto any compare value, the block raises a one-cycle interrupt pulse.

The count moves only when two control bits are both set: a run enable and an oscillator enable. Clearing either bit freezes the count in place. Reads then return the frozen value, and setting both bits again resumes counting from that value. Presetting the count and writing a compare value take effect only while the counter is running. At any other time such writes are dropped without any sign.

The window accepts only full-word accesses. A write that has any byte enable low changes nothing, and a read that has any byte enable low returns zero.

Top module: `tick_cmp_counter`

## Requirements
- R1: After a synchronous reset the control word, the count and every compare value read as zero, and `irq_pulse` is low.
- R2: The counter is running exactly when control bit 13 (run enable) and control bit 8 (oscillator enable) are both 1. While it is running, each cycle with `tick_en` high adds one to the count. A tick that arrives while the counter is not running has no effect.
- R3: A write to offset 0x64 (preset) loads the count with the write data only while the counter is running. A preset in the same cycle as a tick wins, and the count becomes the write data. A preset while the counter is not running is ignored.
- R4: A write to a compare offset (0x6C, 0x70 or 0x74 for slots 0, 1 and 2) stores the write data only while the counter is running. Otherwise the write is ignored and the previous value stays readable.
- R5: Clearing either enable bit freezes the count. Reads of offset 0x68 return the frozen value, and setting both bits again resumes counting from it.
- R6: When a tick moves the count onto a value equal to any compare slot, `irq_pulse` is high for exactly the one cycle after that clock edge.
- R7: A preset that makes the count equal to a compare value raises no pulse.
- R8: The count wraps from 0xFFFFFFFF to 0. A compare slot that holds 0 fires on that wrap.
- R9: Offset 0x40 reads back all 32 bits of the last control write, and control writes are accepted whether or not the counter is running. The preset offset 0x64 and unmapped offsets read as zero. Writes to unmapped offsets, and to the read-only count offset 0x68, change nothing.
- R10: An access whose `bus_be` is not 4'b1111 is rejected: a write changes no register, and the read data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle strobe per slow tick (nominally 32768 Hz) |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| bus_addr | input | 8 | Byte offset inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` and `bus_be` |
| irq_pulse | output | 1 | One-cycle pulse on a compare hit |

## Verification
The bench builds the block with its default parameters: three compare slots and a 32-bit count. With three slots, a single run of ticks can cross several hits as well as a slot that never matches. A preset near the top of the range reaches the 0xFFFFFFFF-to-0 wrap within two ticks, so the wrap and a hit on a compare value of zero can be checked without counting up the whole range. Ticks are driven directly as strobes, which lets the bench count the exact number of pulses and measure how wide each one is.

// File: rtl/tkc_pkg.sv
package tkc_pkg;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned ADDR_W     = 8;
    localparam int unsigned BE_W       = DATA_W / 8;
    localparam int unsigned CMP_STRIDE = BE_W;

    localparam logic [ADDR_W-1:0] OFS_CTRL     = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_PRESET   = 8'h64;
    localparam logic [ADDR_W-1:0] OFS_COUNT    = 8'h68;
    localparam logic [ADDR_W-1:0] OFS_CMP_BASE = 8'h6C;

    localparam int unsigned RUN_BIT = 13;
    localparam int unsigned OSC_BIT = 8;

    typedef struct packed {
        logic              wr;
        logic              full_word;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_access_t;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_CTRL,
        RD_COUNT,
        RD_CMP
    } rd_kind_e;

    function automatic logic ctrl_running(input logic [DATA_W-1:0] ctrl);
        return ctrl[RUN_BIT] & ctrl[OSC_BIT];
    endfunction

    function automatic logic [ADDR_W-1:0] cmp_offset(input int unsigned slot);
        return OFS_CMP_BASE + ADDR_W'(CMP_STRIDE * slot);
    endfunction
endpackage

// File: rtl/tkc_ctrl_regs.sv
module tkc_ctrl_regs
    import tkc_pkg::*;
#(
    parameter int unsigned NUM_CMP = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  bus_access_t                     acc,
    output logic [DATA_W-1:0]               ctrl_q,
    output logic [NUM_CMP-1:0][DATA_W-1:0]  cmp_q,
    output logic                            running
);
    logic accepted_wr;
    assign accepted_wr = acc.wr & acc.full_word;
    assign running     = ctrl_running(ctrl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (accepted_wr && acc.addr == OFS_CTRL) begin
            ctrl_q <= acc.data;
        end
    end

    for (genvar s = 0; s < NUM_CMP; s++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_OFS = cmp_offset(s);
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_q[s] <= '0;
            end else if (accepted_wr && running && acc.addr == SLOT_OFS) begin
                cmp_q[s] <= acc.data;
            end
        end
    end

    // R1: reset clears the control word
    assert_ctrl_reset_R1: assert property (@(posedge clk)
        rst |=> (ctrl_q == '0));

    // R4: compare slots hold while not running
    assert_cmp_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !running |=> $stable(cmp_q));

    // R10: a partial write leaves control untouched
    assert_partial_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && !acc.full_word) |=> $stable(ctrl_q));
endmodule

// File: rtl/tkc_counter.sv
module tkc_counter
    import tkc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              running,
    input  logic              tick_en,
    input  logic              preset_wr,
    input  logic [DATA_W-1:0] preset_val,
    output logic [DATA_W-1:0] count_q,
    output logic              advance,
    output logic [DATA_W-1:0] next_count
);
    logic preset_take;

    assign preset_take = preset_wr & running;
    assign advance     = running & tick_en & ~preset_take;
    assign next_count  = count_q + DATA_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (preset_take) begin
            count_q <= preset_val;
        end else if (advance) begin
            count_q <= next_count;
        end
    end

    // R5: count frozen while not running
    assert_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        !running |=> $stable(count_q));

    // R8: wrap to zero
    assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (advance && count_q == '1) |=> (count_q == '0));

    // R3: accepted preset lands
    assert_preset_R3: assert property (@(posedge clk) disable iff (rst)
        (running && preset_wr) |=> (count_q == $past(preset_val)));
endmodule

// File: rtl/tkc_match.sv
module tkc_match
    import tkc_pkg::*;
#(
    parameter int unsigned NUM_CMP = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           advance,
    input  logic [DATA_W-1:0]              next_count,
    input  logic [NUM_CMP-1:0][DATA_W-1:0] cmp_q,
    output logic                           irq_q
);
    logic [NUM_CMP-1:0] slot_hit;

    for (genvar s = 0; s < NUM_CMP; s++) begin : g_cmp
        assign slot_hit[s] = (next_count == cmp_q[s]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= advance & (|slot_hit);
        end
    end

    // R6 / R7: a pulse only follows a counting tick, never a preset
    assert_pulse_needs_tick_R6: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> $past(advance));
endmodule

// File: rtl/tick_cmp_counter.sv
module tick_cmp_counter
    import tkc_pkg::*;
#(
    parameter int unsigned NUM_CMP = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_pulse
);
    localparam int unsigned SLOT_W = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1;

    bus_access_t                    acc;
    logic [DATA_W-1:0]              ctrl_q;
    logic [NUM_CMP-1:0][DATA_W-1:0] cmp_q;
    logic                           running;
    logic [DATA_W-1:0]              count_q;
    logic                           advance;
    logic [DATA_W-1:0]              next_count;
    rd_kind_e                       rd_kind;
    logic [SLOT_W-1:0]              rd_slot;

    assign acc.wr        = bus_wr;
    assign acc.full_word = (bus_be == '1);
    assign acc.addr      = bus_addr;
    assign acc.data      = bus_wdata;

    tkc_ctrl_regs #(.NUM_CMP(NUM_CMP)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .ctrl_q  (ctrl_q),
        .cmp_q   (cmp_q),
        .running (running)
    );

    tkc_counter cnt_i (
        .clk        (clk),
        .rst        (rst),
        .running    (running),
        .tick_en    (tick_en),
        .preset_wr  (acc.wr && acc.full_word && acc.addr == OFS_PRESET),
        .preset_val (acc.data),
        .count_q    (count_q),
        .advance    (advance),
        .next_count (next_count)
    );

    tkc_match #(.NUM_CMP(NUM_CMP)) match_i (
        .clk        (clk),
        .rst        (rst),
        .advance    (advance),
        .next_count (next_count),
        .cmp_q      (cmp_q),
        .irq_q      (irq_pulse)
    );

    always_comb begin
        rd_kind = RD_NONE;
        rd_slot = '0;
        if (acc.full_word) begin
            if (bus_addr == OFS_CTRL) begin
                rd_kind = RD_CTRL;
            end else if (bus_addr == OFS_COUNT) begin
                rd_kind = RD_COUNT;
            end
            for (int s = 0; s < NUM_CMP; s++) begin
                if (bus_addr == cmp_offset(s)) begin
                    rd_kind = RD_CMP;
                    rd_slot = SLOT_W'(s);
                end
            end
        end
    end

    always_comb begin
        unique case (rd_kind)
            RD_CTRL:  bus_rdata = ctrl_q;
            RD_COUNT: bus_rdata = count_q;
            RD_CMP:   bus_rdata = cmp_q[rd_slot];
            default:  bus_rdata = '0;
        endcase
    end

    // R10: rejected reads return zero
    assert_partial_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_be != '1) |-> (bus_rdata == '0));
endmodule

// File: tb/tick_cmp_counter_tb_top.sv
module tick_cmp_counter_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = 4'hF;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_pulse;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    localparam logic [31:0] RUN_ON = (32'd1 << 13) | (32'd1 << 8);

    always #5 clk = ~clk;

    tick_cmp_counter dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_pulse(irq_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'hF;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_addr = a; bus_be = be;
        #1 d = bus_rdata;
        bus_be = 4'hF;
    endtask

    task automatic ticks(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
            if (irq_pulse) pulses++;
        end
        @(negedge clk);
        check("R6 pulse width", {31'b0, irq_pulse}, 32'd0);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h40, v); check("R1 ctrl", v, 0);
        rd(8'h68, v); check("R1 count", v, 0);
        rd(8'h6C, v); check("R1 cmp0", v, 0);
        rd(8'h70, v); check("R1 cmp1", v, 0);
        rd(8'h74, v); check("R1 cmp2", v, 0);
        check("R1 irq", {31'b0, irq_pulse}, 0);
    endtask

    task automatic t_idle;
        logic [31:0] v; int p;
        ticks(5, p);
        rd(8'h68, v); check("R2 no count when off", v, 0);
        wr(8'h40, 32'd1 << 13);
        ticks(3, p);
        rd(8'h68, v); check("R2 run bit alone", v, 0);
        wr(8'h64, 32'd55);
        rd(8'h68, v); check("R3 preset ignored", v, 0);
        wr(8'h6C, 32'd77);
        rd(8'h6C, v); check("R4 cmp ignored", v, 0);
    endtask

    task automatic t_run;
        logic [31:0] v; int p;
        wr(8'h40, RUN_ON | 32'h5);
        rd(8'h40, v); check("R9 ctrl readback", v, RUN_ON | 32'h5);
        ticks(7, p);
        rd(8'h68, v); check("R2 seven ticks", v, 7);
        wr(8'h64, 32'd100);
        rd(8'h68, v); check("R3 preset", v, 100);
        ticks(3, p);
        rd(8'h68, v); check("R3 count after preset", v, 103);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h64; bus_wdata = 32'd90; tick_en = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
        rd(8'h68, v); check("R3 preset beats tick", v, 90);
        wr(8'h64, 32'd103);
    endtask

    task automatic t_match;
        logic [31:0] v; int p;
        wr(8'h6C, 32'd110); wr(8'h70, 32'd105); wr(8'h74, 32'd200);
        rd(8'h6C, v); check("R4 cmp0", v, 110);
        rd(8'h70, v); check("R4 cmp1", v, 105);
        rd(8'h74, v); check("R4 cmp2", v, 200);
        ticks(10, p);
        check("R6 two hits", p, 2);
        rd(8'h68, v); check("R6 count", v, 113);
        wr(8'h64, 32'd200);
        check("R7 no pulse on preset", {31'b0, irq_pulse}, 0);
        ticks(1, p);
        check("R7 no later pulse", p, 0);
    endtask

    task automatic t_freeze;
        logic [31:0] v; int p;
        wr(8'h40, 32'd1 << 13);
        ticks(4, p);
        rd(8'h68, v); check("R5 frozen", v, 201);
        wr(8'h70, 32'd9);
        rd(8'h70, v); check("R4 cmp held while frozen", v, 105);
        wr(8'h64, 32'd9);
        rd(8'h68, v); check("R3 preset ignored frozen", v, 201);
        wr(8'h40, RUN_ON);
        ticks(2, p);
        rd(8'h68, v); check("R5 resumed", v, 203);
    endtask

    task automatic t_wrap;
        logic [31:0] v; int p;
        wr(8'h64, 32'hFFFF_FFFE);
        wr(8'h6C, 32'd0);
        ticks(2, p);
        rd(8'h68, v); check("R8 wrap", v, 0);
        check("R8 hit at zero", p, 1);
    endtask

    task automatic t_map;
        logic [31:0] v;
        wr(8'h44, 32'hDEAD_BEEF);
        rd(8'h44, v); check("R9 unmapped read", v, 0);
        rd(8'h64, v); check("R9 preset reads zero", v, 0);
        wr(8'h68, 32'h1234);
        rd(8'h68, v); check("R9 count write ignored", v, 0);
        rd(8'h40, v); check("R9 ctrl intact", v, RUN_ON);
        wr(8'h40, 32'd0, 4'h3);
        rd(8'h40, v); check("R10 partial write ignored", v, RUN_ON);
        rd(8'h40, v, 4'h1); check("R10 partial read zero", v, 0);
        wr(8'h6C, 32'd44, 4'h7);
        rd(8'h6C, v); check("R10 partial cmp write", v, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_idle();
        t_run();
        t_match();
        t_freeze();
        t_wrap();
        t_map();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule